// File: doc/BRIEF.md
# Scannable Registered Bus Transceiver

This block is a narrow bidirectional bus slice built entirely from registers. A transmit register captures local data and, while the bus is enabled, places it on a shared bus. A receive register captures the value seen on the bus and presents it on local receive outputs. Each register has its own load/hold control. When the control is low, the register keeps its current contents.

A single enable flip-flop gates the bus drivers. In normal operation it takes the synchronous enable input on every rising clock edge. An asynchronous disable input turns the bus off immediately, without waiting for a clock, and is how the bus is released before scan. A separate asynchronous force-on input can set the enable flip-flop again without a clock. The disable input wins over the force-on input. The tri-state bus is modelled as a data vector plus an output-enable. While the bus is not driven, the data vector is held at zero.

When scan mode is selected, every data register becomes part of one serial shift chain. The chain starts at a dedicated serial input and runs through the transmit bits from low to high, then through the receive bits from low to high. The top receive output serves as the serial output.

Top module: `scan_bus_xcvr`

## Requirements
- R1: While reset is active, and right after it, the transmit and receive registers are zero and the bus output-enable is low.
- R2: With scan mode off, a rising edge with transmit load high captures `tx_data_i` into the transmit register; with transmit load low the register keeps its value whatever `tx_data_i` does.
- R3: With scan mode off, a rising edge with receive load high captures `bus_in_i` into the receive register shown on `rx_data_o`; with receive load low `rx_data_o` keeps its value.
- R4: While `bus_oe_o` is high, `bus_data_o` equals the transmit register bit for bit, without inversion.
- R5: While `bus_oe_o` is low, `bus_data_o` is all zeros.
- R6: On every rising edge, when neither asynchronous control is active, the enable flip-flop takes the value of `bus_en_sync_i` (1 enables the bus, 0 disables it).
- R7: Raising `bus_off_async_i` drops `bus_oe_o` at once without a clock edge, and the bus stays off across clock edges for as long as the input is high.
- R8: Raising `bus_force_on_i` while `bus_off_async_i` is low sets the enable flip-flop at once, so `bus_oe_o` goes high without a clock edge.
- R9: When `bus_off_async_i` and `bus_force_on_i` are both high, the bus stays disabled.
- R10: With scan mode on, every rising edge shifts the chain scan input → transmit bit 0 → … → transmit bit W-1 → receive bit 0 → … → receive bit W-1, and the load controls and parallel data have no effect.
- R11: In scan mode, a bit entered on `scan_in_i` appears on `rx_data_o[W-1]` (the serial output) after 2·W rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock for all registers |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_data_i | input | WIDTH | Local data for the transmit register |
| tx_load_i | input | 1 | Transmit load (1) / hold (0) |
| bus_in_i | input | WIDTH | Value seen on the shared bus |
| rx_load_i | input | 1 | Receive load (1) / hold (0) |
| bus_en_sync_i | input | 1 | Synchronous bus enable, sampled each edge |
| bus_off_async_i | input | 1 | Asynchronous bus disable, active high |
| bus_force_on_i | input | 1 | Asynchronous set of the bus enable, active high |
| scan_mode_i | input | 1 | Scan mode select, active high |
| scan_in_i | input | 1 | Serial scan data input |
| bus_data_o | output | WIDTH | Bus drive data, zero when not driven |
| bus_oe_o | output | 1 | Bus output-enable |
| rx_data_o | output | WIDTH | Receive register; MSB is the scan output |

## Verification
The hardest case to reach from the ports is the interplay of the two asynchronous controls with the clocked enable. The bus must drop and come back between clock edges. The disable must also win while force-on is held across several edges. The stimulus changes these inputs halfway between edges and compares the outputs before the next edge. It holds both controls high over several edges while the synchronous enable requests the bus. The scan phase then pushes a known serial pattern with the load controls and data held active, and reads it back on the serial output after the full chain delay.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_LOAD  = 2'd1,
      OP_SHIFT = 2'd2
   } reg_op_e;

   function automatic reg_op_e pick_op(input logic shift, input logic load);
      if (shift)     return OP_SHIFT;
      else if (load) return OP_LOAD;
      else           return OP_HOLD;
   endfunction

endpackage

// File: rtl/xcvr_data_reg.sv
module xcvr_data_reg
   import xcvr_pkg::*;
#(
   parameter int WIDTH = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             shift_i,
   input  logic             load_i,
   input  logic [WIDTH-1:0] par_d_i,
   input  logic             ser_d_i,
   output logic [WIDTH-1:0] q_o
);

   logic [WIDTH-1:0] q_r;
   logic [WIDTH-1:0] shifted;
   reg_op_e          op;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("xcvr_data_reg: WIDTH must be at least 1");
      end
      if (WIDTH == 1) begin : g_shift_single
         assign shifted = ser_d_i;
      end else begin : g_shift_multi
         assign shifted = {q_r[WIDTH-2:0], ser_d_i};
      end
   endgenerate

   assign op = pick_op(shift_i, load_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         q_r <= '0;
      end else begin
         case (op)
            OP_SHIFT: q_r <= shifted;
            OP_LOAD:  q_r <= par_d_i;
            default:  q_r <= q_r;
         endcase
      end
   end

   assign q_o = q_r;

   AST_HOLD_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!shift_i && !load_i) |=> (q_o == $past(q_o))); // R2, R3

   AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!shift_i && load_i) |=> (q_o == $past(par_d_i))); // R2, R3

   AST_SHIFT_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      shift_i |=> (q_o[0] == $past(ser_d_i))); // R10

endmodule

// File: rtl/xcvr_bus_enable.sv
module xcvr_bus_enable (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sync_en_i,
   input  logic off_i,
   input  logic set_i,
   output logic en_o
);

   logic en_q;

   always_ff @(posedge clk_i or negedge rst_ni or posedge off_i or posedge set_i) begin
      if (!rst_ni)     en_q <= 1'b0;
      else if (off_i)  en_q <= 1'b0;
      else if (set_i)  en_q <= 1'b1;
      else             en_q <= sync_en_i;
   end

   assign en_o = en_q;

   AST_OFF_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      off_i |-> !en_q); // R7

   AST_OFF_BEATS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (off_i && set_i) |-> !en_q); // R9

   AST_SET_FORCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i && !off_i) |-> en_q); // R8

   AST_SYNC_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!off_i && !set_i) |=> ((en_q == $past(sync_en_i)) || off_i || set_i)); // R6

endmodule

// File: rtl/scan_bus_xcvr.sv
module scan_bus_xcvr #(
   parameter int WIDTH = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] tx_data_i,
   input  logic             tx_load_i,
   input  logic [WIDTH-1:0] bus_in_i,
   input  logic             rx_load_i,
   input  logic             bus_en_sync_i,
   input  logic             bus_off_async_i,
   input  logic             bus_force_on_i,
   input  logic             scan_mode_i,
   input  logic             scan_in_i,
   output logic [WIDTH-1:0] bus_data_o,
   output logic             bus_oe_o,
   output logic [WIDTH-1:0] rx_data_o
);

   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] tx_q;
   logic [WIDTH-1:0] rx_q;
   logic             en_q;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("scan_bus_xcvr: WIDTH must be at least 1");
      end
   endgenerate

   xcvr_data_reg #(.WIDTH(WIDTH)) u_tx_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .shift_i (scan_mode_i),
      .load_i  (tx_load_i),
      .par_d_i (tx_data_i),
      .ser_d_i (scan_in_i),
      .q_o     (tx_q)
   );

   xcvr_data_reg #(.WIDTH(WIDTH)) u_rx_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .shift_i (scan_mode_i),
      .load_i  (rx_load_i),
      .par_d_i (bus_in_i),
      .ser_d_i (tx_q[MSB]),
      .q_o     (rx_q)
   );

   xcvr_bus_enable u_bus_en (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sync_en_i (bus_en_sync_i),
      .off_i     (bus_off_async_i),
      .set_i     (bus_force_on_i),
      .en_o      (en_q)
   );

   assign bus_oe_o = en_q & ~bus_off_async_i;

   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_bus_gate
         assign bus_data_o[b] = bus_oe_o & tx_q[b];
      end
   endgenerate

   assign rx_data_o = rx_q;

   AST_CHAIN_LINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      scan_mode_i |=> (rx_q[0] == $past(tx_q[MSB]))); // R10

   AST_RESET_QUIET: assert property (@(posedge clk_i)
      !rst_ni |-> (!bus_oe_o && (rx_data_o == '0))); // R1

endmodule

// File: tb/test_scan_bus_xcvr.sv
module test_scan_bus_xcvr;

   localparam int W = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] tx_data = '0;
   logic         tx_load = 1'b0;
   logic [W-1:0] bus_in = '0;
   logic         rx_load = 1'b0;
   logic         sync_en = 1'b0;
   logic         bus_off = 1'b0;
   logic         force_on = 1'b0;
   logic         scan = 1'b0;
   logic         scan_in = 1'b0;
   logic [W-1:0] bus_data;
   logic         bus_oe;
   logic [W-1:0] rx_data;

   int checks = 0;
   int failures = 0;
   string tag = "R1";
   bit finished = 0;

   bit [W-1:0] m_tx = '0;
   bit [W-1:0] m_rx = '0;
   bit         m_en = 0;

   always #4 clk = ~clk;

   scan_bus_xcvr #(.WIDTH(W)) i_scan_bus_xcvr (
      .clk_i(clk), .rst_ni(rst_n), .tx_data_i(tx_data), .tx_load_i(tx_load),
      .bus_in_i(bus_in), .rx_load_i(rx_load), .bus_en_sync_i(sync_en),
      .bus_off_async_i(bus_off), .bus_force_on_i(force_on),
      .scan_mode_i(scan), .scan_in_i(scan_in),
      .bus_data_o(bus_data), .bus_oe_o(bus_oe), .rx_data_o(rx_data)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      bit exp_oe;
      exp_oe = m_en && !bus_off;
      check(tag, "bus_oe", int'(bus_oe), int'(exp_oe));
      check(tag, "bus_data", int'(bus_data), exp_oe ? int'(m_tx) : 0);
      check(tag, "rx_data", int'(rx_data), int'(m_rx));
   endtask

   // reference model, updated at every rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_tx = '0; m_rx = '0; m_en = 0;
      end else begin
         if (scan) begin
            bit ch[$];
            for (int i = 0; i < W; i++) ch.push_back(m_tx[i]);
            for (int i = 0; i < W; i++) ch.push_back(m_rx[i]);
            ch.push_front(scan_in);
            void'(ch.pop_back());
            for (int i = 0; i < W; i++) begin
               m_tx[i] = ch[i];
               m_rx[i] = ch[W+i];
            end
         end else begin
            if (tx_load) m_tx = tx_data;
            if (rx_load) m_rx = bus_in;
         end
         if (bus_off)       m_en = 0;
         else if (force_on) m_en = 1;
         else               m_en = sync_en;
      end
      #2;
      if (!finished) compare_all();
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #(8 * 200000);
      failures++;
      $display("FAIL watchdog expired, actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      // R1: reset
      tag = "R1";
      tx_data = 3'b111; tx_load = 1; bus_in = 3'b101; rx_load = 1; sync_en = 1;
      step(3);
      check("R1", "oe in reset", int'(bus_oe), 0);
      check("R1", "rx in reset", int'(rx_data), 0);
      tx_load = 0; rx_load = 0; sync_en = 0;
      rst_n = 1;
      step(1);
      check("R1", "rx after reset", int'(rx_data), 0);

      // R6: synchronous enable
      tag = "R6";
      sync_en = 1;
      step(1);
      check("R6", "oe after sync enable", int'(bus_oe), 1);

      // R2 / R4: transmit load and hold
      tag = "R2";
      tx_data = 3'b101; tx_load = 1; step(1);
      check("R4", "bus data non-inverted", int'(bus_data), 5);
      tx_load = 0; tx_data = 3'b010; step(2);
      check("R2", "tx hold", int'(bus_data), 5);
      tx_data = 3'b011; tx_load = 1; step(1);
      tx_data = 3'b110; step(1);
      check("R4", "bus data 110", int'(bus_data), 6);
      tx_load = 0;

      // R3: receive load and hold
      tag = "R3";
      bus_in = 3'b011; rx_load = 1; step(1);
      check("R3", "rx load", int'(rx_data), 3);
      rx_load = 0; bus_in = 3'b100; step(2);
      check("R3", "rx hold", int'(rx_data), 3);
      rx_load = 1; step(1);
      rx_load = 0; bus_in = 3'b111;
      step(1);
      check("R3", "rx second load", int'(rx_data), 4);

      // R5 / R6: synchronous disable
      tag = "R5";
      sync_en = 0; step(1);
      check("R5", "bus data zero when off", int'(bus_data), 0);
      check("R6", "oe after sync disable", int'(bus_oe), 0);
      sync_en = 1; step(1);

      // R7: asynchronous disable mid-cycle
      tag = "R7";
      #1 bus_off = 1; m_en = 0;
      #1;
      check("R7", "oe drops at once", int'(bus_oe), 0);
      check("R5", "bus data zero at once", int'(bus_data), 0);
      step(3);
      check("R7", "stays off with sync enable", int'(bus_oe), 0);

      // R9: disable wins over force-on
      tag = "R9";
      #1 force_on = 1;
      #1;
      check("R9", "both active, oe", int'(bus_oe), 0);
      step(3);
      check("R9", "both active over edges", int'(bus_oe), 0);
      force_on = 0; sync_en = 0;
      step(1);
      bus_off = 0;
      step(2);
      check("R6", "stays off with sync low", int'(bus_oe), 0);

      // R8: asynchronous force-on mid-cycle
      tag = "R8";
      #1 force_on = 1; m_en = 1;
      #1;
      check("R8", "oe rises at once", int'(bus_oe), 1);
      check("R4", "bus data after force", int'(bus_data), 6);
      step(2);
      force_on = 0;
      step(1);
      check("R6", "sync low clears after force", int'(bus_oe), 0);

      // R10 / R11: scan shift with loads active
      tag = "R10";
      bus_off = 1;
      step(1);
      scan = 1; tx_load = 1; rx_load = 1; tx_data = 3'b111; bus_in = 3'b111;
      begin
         bit pat[8] = '{1, 0, 0, 1, 1, 1, 0, 1};
         for (int k = 0; k < 8; k++) begin
            scan_in = pat[k];
            step(1);
            if (k >= 2*W - 1)
               check("R11", "serial out", int'(rx_data[W-1]), int'(pat[k - (2*W - 1)]));
         end
      end
      check("R10", "tx after scan", int'(bus_data), 0);
      tag = "R11";
      scan_in = 0;
      step(2);
      scan = 0; tx_load = 0; rx_load = 0; bus_off = 0; sync_en = 1;
      step(1);
      tag = "R4";
      step(2);
      check("R10", "tx contents from chain visible", int'(bus_data), int'(m_tx));

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule